// File: doc/BRIEF.md
# Eight-Pin Input Glitch Qualifier

This block cleans up a group of eight asynchronous input pins before the rest of the chip uses them. Each raw pin first goes through a two-flop synchronizer. It is then either passed straight on or run through a filter that takes samples and only accepts a new level once enough consecutive samples agree on it. All eight pins share one sample strobe. The strobe comes from an 8-bit period setting: a setting of zero samples on every clock, and a setting n samples once every 2n clocks.

Each pin has its own 2-bit mode. In synchronous mode the synchronized level goes directly to the output register. In the two qualified modes the output only moves after 3, or 6, consecutive samples carry the same level and that level differs from the current output. A pulse shorter than the qualification window (one sampling period times the sample count minus one) therefore never reaches the output. Every pin here is a plain level signal, so the block has no valid/ready handshake and no back-pressure. A qualified level is simply present on its output on every cycle.

Top module: `gpio_qual_bank`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, every bit of `qual_o` is 0. The sample history and the strobe counter are cleared, and a cleared history counts as six samples of 0.
- R2: Every pin passes through two flops before it is used. In synchronous mode (mode code 00, and code 11, which behaves the same way) a level driven on `pin_i[k]` shows on `qual_o[k]` after the third rising clock edge.
- R3: With `period_i` = 0 and unchanged, the sample strobe is active on every clock cycle.
- R4: With `period_i` = n > 0 and unchanged, the strobe is active on exactly one cycle in every 2n, so two strobes never fall on adjacent cycles.
- R5: In 3-sample mode (code 01) a pin's output takes a new level once three consecutive strobe samples of the synchronized pin equal that level. With period 0, the output changes after the fifth edge that follows a change on the pin.
- R6: In 6-sample mode (code 10) six consecutive equal samples are needed. With period 0, the output changes after the eighth edge.
- R7: A pulse that fewer consecutive samples catch than the pin's mode requires leaves the output unchanged.
- R8: The period setting is shared by all eight pins. Mode select k sits in `mode_i[2k+1:2k]` and acts on pin k only.
- R9: Any change of `period_i` suppresses the strobe in that cycle and restarts the strobe counter from zero.
- R10: In a qualified mode a pin's output can change only on the clock edge that ends a strobe cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pin_i | input | 8 | Raw asynchronous input pins |
| period_i | input | 8 | Shared sampling-period setting |
| mode_i | input | 16 | Per-pin mode; pin k uses bits [2k+1:2k] |
| qual_o | output | 8 | Qualified pin levels |

## Verification
The assertions check the strobe on every cycle: it is active whenever the period is zero, it never fires twice in a row for a non-zero period, and it is suppressed when the setting changes. They also check that a qualified output stays still outside strobe cycles and that a synchronous-mode output follows its synchronizer one cycle later. Only the bench's scenarios can show the exact counts of agreeing samples, the rejection of glitches of a given width, the latency through the synchronizer, and the exact phase of the strobe after a restart. For these the bench compares against a cycle-level reference model and adds directed checks at known cycle offsets.

// File: rtl/gq_pkg.sv
package gq_pkg;
  typedef enum logic [1:0] {
    MODE_SYNC     = 2'b00,
    MODE_Q3       = 2'b01,
    MODE_Q6       = 2'b10,
    MODE_SYNC_ALT = 2'b11
  } qual_mode_e;

  localparam int SHORT_CNT = 3;
  localparam int LONG_CNT  = 6;

  function automatic logic is_qualified(input logic [1:0] m);
    return (m == MODE_Q3) || (m == MODE_Q6);
  endfunction
endpackage

// File: rtl/gq_sync2.sv
module gq_sync2 #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= d_i;
      stab_q <= meta_q;
    end
  end

  assign q_o = stab_q;
endmodule

// File: rtl/gq_strobe_gen.sv
module gq_strobe_gen #(
  parameter int PRD_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PRD_W-1:0] period_i,
  output logic             strobe_o
);
  localparam int CW = PRD_W + 1;

  logic [PRD_W-1:0] prd_q;
  logic [CW-1:0]    cnt_q;
  logic [CW-1:0]    limit;
  logic             changed;
  logic             is_zero;
  logic             at_end;

  assign limit    = {period_i, 1'b0} - CW'(1);
  assign changed  = (period_i != prd_q);
  assign is_zero  = (period_i == '0);
  assign at_end   = (cnt_q == limit);
  assign strobe_o = !changed && (is_zero || at_end);

  always_ff @(posedge clk) begin
    if (rst) begin
      prd_q <= '0;
      cnt_q <= '0;
    end else begin
      prd_q <= period_i;
      if (changed || is_zero || at_end) cnt_q <= '0;
      else                              cnt_q <= cnt_q + CW'(1);
    end
  end
endmodule

// File: rtl/gq_pin_filter.sv
module gq_pin_filter
  import gq_pkg::*;
#(
  parameter int SHORT = SHORT_CNT,
  parameter int LONG  = LONG_CNT
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       smp_i,
  input  logic       stb_i,
  input  logic [1:0] mode_i,
  output logic       q_o
);
  localparam logic [LONG-1:0] SHORT_MASK = LONG'((1 << SHORT) - 1);

  logic [LONG-1:0] hist_q;
  logic [LONG-1:0] hist_n;
  logic            q_q;
  logic            q_n;
  logic            short_hi, short_lo, long_hi, long_lo;
  qual_mode_e      mode;

  assign mode     = qual_mode_e'(mode_i);
  assign hist_n   = {hist_q[LONG-2:0], smp_i};
  assign short_hi = ((hist_n & SHORT_MASK) == SHORT_MASK);
  assign short_lo = ((hist_n & SHORT_MASK) == '0);
  assign long_hi  = &hist_n;
  assign long_lo  = ~|hist_n;

  always_comb begin
    q_n = q_q;
    case (mode)
      MODE_Q3: begin
        if (stb_i && short_hi)      q_n = 1'b1;
        else if (stb_i && short_lo) q_n = 1'b0;
      end
      MODE_Q6: begin
        if (stb_i && long_hi)      q_n = 1'b1;
        else if (stb_i && long_lo) q_n = 1'b0;
      end
      default: q_n = smp_i;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_q <= '0;
      q_q    <= 1'b0;
    end else begin
      if (stb_i) hist_q <= hist_n;
      q_q <= q_n;
    end
  end

  assign q_o = q_q;
endmodule

// File: rtl/gpio_qual_bank.sv
module gpio_qual_bank #(
  parameter int PINS  = 8,
  parameter int PRD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PINS-1:0]   pin_i,
  input  logic [PRD_W-1:0]  period_i,
  input  logic [2*PINS-1:0] mode_i,
  output logic [PINS-1:0]   qual_o
);
  logic [PINS-1:0] pin_sync;
  logic            strobe;

  gq_sync2 #(.W(PINS)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (pin_i),
    .q_o (pin_sync)
  );

  gq_strobe_gen #(.PRD_W(PRD_W)) u_stb (
    .clk      (clk),
    .rst      (rst),
    .period_i (period_i),
    .strobe_o (strobe)
  );

  for (genvar k = 0; k < PINS; k++) begin : g_pin
    gq_pin_filter u_flt (
      .clk    (clk),
      .rst    (rst),
      .smp_i  (pin_sync[k]),
      .stb_i  (strobe),
      .mode_i (mode_i[2*k +: 2]),
      .q_o    (qual_o[k])
    );
  end
endmodule

// File: rtl/gq_checker.sv
module gq_checker
  import gq_pkg::*;
#(
  parameter int PINS  = 8,
  parameter int PRD_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [PRD_W-1:0]  period_i,
  input logic [2*PINS-1:0] mode_i,
  input logic [PINS-1:0]   pin_sync,
  input logic              strobe,
  input logic [PINS-1:0]   qual_o
);
  AST_RESET_CLEAR: assert property (@(posedge clk) $fell(rst) |-> qual_o == '0); // R1

  AST_ZERO_EVERY_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (period_i == '0 && $stable(period_i)) |-> strobe); // R3

  AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (rst)
    (strobe && period_i != '0) |=> !strobe); // R4

  AST_RESTART_ON_CHANGE: assert property (@(posedge clk) disable iff (rst)
    !$stable(period_i) |-> !strobe); // R9

  for (genvar k = 0; k < PINS; k++) begin : g_chk
    AST_SYNC_FOLLOW: assert property (@(posedge clk) disable iff (rst)
      !is_qualified(mode_i[2*k +: 2]) |=> qual_o[k] == $past(pin_sync[k])); // R2

    AST_HOLD_OFF_STROBE: assert property (@(posedge clk) disable iff (rst)
      (is_qualified(mode_i[2*k +: 2]) && !strobe) |=> $stable(qual_o[k])); // R10
  end
endmodule

bind gpio_qual_bank gq_checker #(.PINS(PINS), .PRD_W(PRD_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .period_i (period_i),
  .mode_i   (mode_i),
  .pin_sync (pin_sync),
  .strobe   (strobe),
  .qual_o   (qual_o)
);

// File: tb/sim_gpio_qual_bank.sv
module sim_gpio_qual_bank;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  pin_i = '0;
  logic [7:0]  period_i = '0;
  logic [15:0] mode_i = '0;
  logic [7:0]  qual_o;

  int    n_cmp = 0;
  int    n_bad = 0;
  bit    done  = 0;
  string cur_req = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_qual_bank u0 (
    .clk(clk), .rst(rst), .pin_i(pin_i), .period_i(period_i),
    .mode_i(mode_i), .qual_o(qual_o)
  );

  // Reference model: integer state, updated once per rising edge
  int m_s1[8], m_s2[8], m_q[8], m_lvl[8], m_run[8];
  int m_cnt, m_prev;

  always @(posedge clk) begin
    int p, need, stb;
    p = int'(period_i);
    if (rst) begin
      for (int k = 0; k < 8; k++) begin
        m_s1[k] = 0; m_s2[k] = 0; m_q[k] = 0; m_lvl[k] = 0; m_run[k] = 6;
      end
      m_cnt = 0; m_prev = 0;
    end else begin
      if (p != m_prev)          begin stb = 0; m_cnt = 0; end
      else if (p == 0)          begin stb = 1; m_cnt = 0; end
      else if (m_cnt == 2*p-1)  begin stb = 1; m_cnt = 0; end
      else                      begin stb = 0; m_cnt++;   end
      m_prev = p;
      for (int k = 0; k < 8; k++) begin
        case (mode_i[2*k +: 2])
          2'b01:   need = 3;
          2'b10:   need = 6;
          default: need = 0;
        endcase
        if (stb) begin
          if (m_s2[k] == m_lvl[k]) m_run[k] = (m_run[k] < 6) ? m_run[k] + 1 : 6;
          else begin m_lvl[k] = m_s2[k]; m_run[k] = 1; end
        end
        if (need == 0) m_q[k] = m_s2[k];
        else if (stb && m_run[k] >= need) m_q[k] = m_lvl[k];
        m_s2[k] = m_s1[k];
        m_s1[k] = int'(pin_i[k]);
      end
    end
  end

  function automatic logic [7:0] model_out();
    logic [7:0] v;
    for (int k = 0; k < 8; k++) v[k] = m_q[k][0];
    return v;
  endfunction

  always @(negedge clk) begin
    if (!rst && !done) begin
      n_cmp++;
      if (qual_o !== model_out()) begin
        n_bad++;
        $display("FAIL %s cycle-compare: actual %h expected %h at %0t",
                 cur_req, qual_o, model_out(), $time);
      end
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    logic [15:0] lfsr;
    cyc(3);
    chk("R1", qual_o, 8'h00);
    @(negedge clk) rst = 1'b0;
    chk("R1", qual_o, 8'h00);
    cyc(4);

    // R2: synchronous mode, three-edge latency
    cur_req = "R2";
    pin_i = 8'hA5;
    cyc(2); chk("R2", qual_o, 8'h00);
    cyc(1); chk("R2", qual_o, 8'hA5);
    pin_i = 8'h00; cyc(6);

    // R5 with R3: 3-sample mode, period 0
    cur_req = "R5"; mode_i = 16'h5555; cyc(10);
    pin_i = 8'hFF;
    cyc(4); chk("R5", qual_o, 8'h00);
    cyc(1); chk("R3", qual_o, 8'hFF);

    // R6: 6-sample mode, period 0
    cur_req = "R6"; mode_i = 16'hAAAA; cyc(10);
    pin_i = 8'h00;
    cyc(7); chk("R6", qual_o, 8'hFF);
    cyc(1); chk("R6", qual_o, 8'h00);

    // R7: glitches shorter than the window
    cur_req = "R7"; cyc(8);
    pin_i = 8'hFF; cyc(5); pin_i = 8'h00; cyc(12);
    chk("R7", qual_o, 8'h00);
    mode_i = 16'h5555; cyc(8);
    pin_i = 8'h3C; cyc(2); pin_i = 8'h00; cyc(10);
    chk("R7", qual_o, 8'h00);

    // R4: period 2 -> strobe every 4 cycles; 7-cycle pulse catches at most 2 samples
    cur_req = "R4"; period_i = 8'd2; cyc(20);
    pin_i = 8'hF0; cyc(7); pin_i = 8'h00; cyc(20);
    chk("R7", qual_o, 8'h00);
    pin_i = 8'h0F; cyc(20);
    chk("R4", qual_o, 8'h0F);

    // R10: long period, output moves only on strobe edges
    cur_req = "R10"; period_i = 8'd5; cyc(30);
    pin_i = 8'hFF; cyc(40);
    chk("R10", qual_o, 8'hFF);

    // R8: mixed per-pin modes, shared period
    cur_req = "R8"; period_i = 8'd1;
    mode_i = 16'b11_11_10_10_01_01_00_00;
    pin_i = 8'h00; cyc(30);
    chk("R8", qual_o, 8'h00);
    pin_i = 8'hFF; cyc(3);
    chk("R8", qual_o, 8'hC3);
    cyc(30);
    chk("R8", qual_o, 8'hFF);

    // R9: period changes mid-stream plus pseudo-random stimulus
    cur_req = "R9";
    lfsr = 16'hACE1;
    for (int i = 0; i < 4000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[3:0] < 4'd6) pin_i[lfsr[6:4]] = ~pin_i[lfsr[6:4]];
      if (i % 300 == 0) period_i = {5'd0, lfsr[9:7]};
      if (i % 700 == 0) mode_i = {lfsr, lfsr} >> lfsr[3:0];
      if (i == 2000) cur_req = "R8";
      @(negedge clk);
    end

    finish_run();
  end
endmodule